// File: doc/BRIEF.md
# Multi-View FIFO Communication Cell

This block is a single inter-thread communication cell: a small circular data queue guarded by a status tag. Threads reach the cell through one request port. Address bits 6:3 pick the access view, and the view sets what a read or write means. A thread can peek at or patch the queue without changing its state. It can read or rewrite the status tag. It can push and pop with empty/full handshaking, in either a blocking or a non-blocking flavour.

A blocking access that cannot complete does not change the queue. It records the requesting thread in a blocked-thread mask and answers with a stall flag. The processor side then parks that thread. The next handshaked access that completes pulses a wake line for every thread in the mask and clears the mask. Every request gets a response in the following cycle.

Top module: `mvf_cell`

## Requirements
- R1: After reset the tag word read through view 1 is 0x30020001. This means Empty (bit 0) is 1, Full (bit 1) is 0, Trigger (bit 16) is 0, the queue flag (bit 17) is 1, the fill count (4 bits from bit 18) is 0, and the depth code (4 bits from bit 28) is 3, which is log2 of the default depth 8.
- R2: Each request accepted while req_valid is high gives resp_valid high in the next cycle, with resp_rdata and resp_stall for that request. Write responses carry zero data. resp_valid is low in a cycle that follows no request.
- R3: A view-1 write loads Trigger, Empty and Full from write-data bits 16, 0 and 1 and ignores all other bits. When the new Empty is 1, the fill count is cleared to 0.
- R4: A completing handshaked write (view 2 blocking, view 3 try) clears Empty. If the fill count is below the depth, it stores the data at the tail and increments the count. It sets Full when the count reaches the depth. A try write to a queue holding the full depth stores nothing.
- R5: A completing handshaked read (view 2 or 3) clears Full. If the count is nonzero it returns the oldest entry and removes it. It sets Empty whenever the count is then zero. A read with a count of zero returns 0.
- R6: A view-2 read while Empty is set, or a view-2 write while Full is set, responds with resp_stall high. It sets the bit of req_tid in the blocked mask and changes nothing else.
- R7: A completing view-2 or view-3 access made while the blocked mask is nonzero drives wake equal to that mask in the response cycle and clears the mask. wake is zero otherwise.
- R8: A view-0 read returns the oldest entry without removing it. A view-0 write overwrites the newest entry when the count is nonzero and has no effect when it is zero.
- R9: Views 4 and 5 read as 0 and ignore writes. Views 6 to 15 read as all ones and ignore writes.
- R10: The head and tail positions wrap modulo the depth, so entries leave in the order they entered across the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address; bits 6:3 select the view |
| req_tid | input | TID_W | Requesting thread number |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response present (cycle after request) |
| resp_stall | output | 1 | Blocking request could not complete |
| resp_rdata | output | DATA_W | Read data |
| wake | output | NTHR | One-cycle wake pulse per previously blocked thread |

## Verification
A fill count or head index that has drifted shows up in the next tag-word read, because the count sits in bits 21:18. It also shows up in the next pop, one cycle after the request, as data out of order or a wrong zero. A lost blocked-mask bit shows up as a missing wake pulse in the response cycle of the first completing handshaked access. A wrongly set Full or Empty turns a blocking access into an unexpected stall in its own response cycle. The sequences cross the wrap point and fill the queue completely, so errors in the index arithmetic reach the data port.

// File: rtl/mvf_pkg.sv
package mvf_pkg;

  typedef enum logic [3:0] {
    VW_RAW     = 4'd0,
    VW_TAG     = 4'd1,
    VW_EF_BLK  = 4'd2,
    VW_EF_TRY  = 4'd3,
    VW_SEM_BLK = 4'd4,
    VW_SEM_TRY = 4'd5
  } view_e;

  // tag word bit layout (decoded by software, so positions are fixed)
  localparam int TAG_E_BIT     = 0;
  localparam int TAG_F_BIT     = 1;
  localparam int TAG_T_BIT     = 16;
  localparam int TAG_Q_BIT     = 17;
  localparam int TAG_PTR_LSB   = 18;
  localparam int TAG_DCODE_LSB = 28;
  localparam int TAG_DCODE_W   = 4;

  typedef struct packed {
    logic raw_rd;
    logic raw_wr;
    logic tag_rd;
    logic tag_wr;
    logic ef_rd;
    logic ef_wr;
    logic ef_blk;
    logic bad_rd;
  } op_t;

endpackage

// File: rtl/mvf_view_decode.sv
module mvf_view_decode
  import mvf_pkg::*;
(
  input  logic       valid,
  input  logic       write,
  input  logic [3:0] view,
  output op_t        op
);

  always_comb begin
    op = '0;
    if (valid) begin
      unique case (view)
        VW_RAW:    begin op.raw_rd = !write; op.raw_wr = write; end
        VW_TAG:    begin op.tag_rd = !write; op.tag_wr = write; end
        VW_EF_BLK: begin op.ef_rd = !write; op.ef_wr = write; op.ef_blk = 1'b1; end
        VW_EF_TRY: begin op.ef_rd = !write; op.ef_wr = write; end
        VW_SEM_BLK, VW_SEM_TRY: ;
        default:   op.bad_rd = !write;
      endcase
    end
  end

endmodule

// File: rtl/mvf_buffer.sv
module mvf_buffer #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata_q <= mem[raddr];
  end

endmodule

// File: rtl/mvf_tag_ctrl.sv
module mvf_tag_ctrl
  import mvf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NTHR   = 8,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(DEPTH + 1),
  localparam int TID_W = $clog2(NTHR)
) (
  input  logic              clk,
  input  logic              rst,
  input  op_t               op,
  input  logic [TID_W-1:0]  tid,
  input  logic [DATA_W-1:0] wdata,
  output logic              e_q,
  output logic              f_q,
  output logic              t_q,
  output logic [PW-1:0]     ptr_q,
  output logic [AW-1:0]     rd_idx_q,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic              do_pop,
  output logic              stall_q,
  output logic [NTHR-1:0]   wake_q
);

  localparam logic [PW-1:0] PFULL = PW'(DEPTH);

  logic [NTHR-1:0] blocked_q;
  logic            ef_stall, ef_done, do_push, raw_patch;
  logic [PW-1:0]   ptr_n;

  always_comb begin
    ef_stall  = op.ef_blk && ((op.ef_rd && e_q) || (op.ef_wr && f_q));
    ef_done   = (op.ef_rd || op.ef_wr) && !ef_stall;
    do_pop    = op.ef_rd && !ef_stall && (ptr_q != '0);
    do_push   = op.ef_wr && !ef_stall && (ptr_q < PFULL);
    raw_patch = op.raw_wr && (ptr_q != '0);
    mem_we    = do_push || raw_patch;
    mem_waddr = do_push ? AW'(rd_idx_q + ptr_q[AW-1:0])
                        : AW'(rd_idx_q + ptr_q[AW-1:0] - AW'(1));
    ptr_n     = ptr_q;
    if (do_pop)  ptr_n = ptr_q - PW'(1);
    if (do_push) ptr_n = ptr_q + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_q       <= 1'b1;
      f_q       <= 1'b0;
      t_q       <= 1'b0;
      ptr_q     <= '0;
      rd_idx_q  <= '0;
      blocked_q <= '0;
      wake_q    <= '0;
      stall_q   <= 1'b0;
    end else begin
      stall_q <= ef_stall;
      wake_q  <= '0;
      if (op.tag_wr) begin
        t_q <= wdata[TAG_T_BIT];
        e_q <= wdata[TAG_E_BIT];
        f_q <= wdata[TAG_F_BIT];
        if (wdata[TAG_E_BIT]) ptr_q <= '0;
      end
      if (ef_stall) blocked_q[tid] <= 1'b1;
      if (ef_done) begin
        ptr_q <= ptr_n;
        if (|blocked_q) begin
          wake_q    <= blocked_q;
          blocked_q <= '0;
        end
        if (do_pop) rd_idx_q <= rd_idx_q + AW'(1);
        if (op.ef_rd) begin
          f_q <= 1'b0;
          if (ptr_n == '0) e_q <= 1'b1;
        end else begin
          e_q <= 1'b0;
          if (ptr_n == PFULL) f_q <= 1'b1;
        end
      end
    end
  end

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PFULL); // R4
  AST_FULL_ON_FILL: assert property (@(posedge clk) disable iff (rst)
    (ptr_q == PFULL && $past(ptr_q) != PFULL) |-> f_q); // R4
  AST_EMPTY_ON_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (ptr_q == '0 && $past(ptr_q) != '0) |-> e_q); // R5
  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (rst)
    stall_q |-> (ptr_q == $past(ptr_q) && rd_idx_q == $past(rd_idx_q))); // R6
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|wake_q) |-> (blocked_q == '0)); // R7
  AST_STALL_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
    stall_q |-> (wake_q == '0)); // R7

endmodule

// File: rtl/mvf_cell.sv
module mvf_cell
  import mvf_pkg::*;
#(
  parameter int DEPTH  = 8,   // power of two
  parameter int NTHR   = 8,
  parameter int DATA_W = 32,  // at least 32 to hold the tag word
  parameter int ADDR_W = 12,  // at least 7 to hold the view field
  localparam int TID_W = $clog2(NTHR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic              resp_stall,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [NTHR-1:0]   wake
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [TAG_DCODE_W-1:0] DCODE = TAG_DCODE_W'(AW);

  op_t               op;
  logic              e_q, f_q, t_q, mem_we, do_pop;
  logic [PW-1:0]     ptr_q;
  logic [AW-1:0]     rd_idx_q, mem_waddr;
  logic [DATA_W-1:0] mem_q, tag_word, side_d, side_q;
  logic              sel_mem_q;

  mvf_view_decode u_dec (
    .valid (req_valid),
    .write (req_write),
    .view  (req_addr[6:3]),
    .op    (op)
  );

  mvf_tag_ctrl #(.DEPTH(DEPTH), .NTHR(NTHR), .DATA_W(DATA_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .tid       (req_tid),
    .wdata     (req_wdata),
    .e_q       (e_q),
    .f_q       (f_q),
    .t_q       (t_q),
    .ptr_q     (ptr_q),
    .rd_idx_q  (rd_idx_q),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .do_pop    (do_pop),
    .stall_q   (resp_stall),
    .wake_q    (wake)
  );

  mvf_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (req_wdata),
    .raddr   (rd_idx_q),
    .rdata_q (mem_q)
  );

  always_comb begin
    tag_word = '0;
    tag_word[TAG_E_BIT] = e_q;
    tag_word[TAG_F_BIT] = f_q;
    tag_word[TAG_T_BIT] = t_q;
    tag_word[TAG_Q_BIT] = 1'b1;
    tag_word[TAG_PTR_LSB +: PW] = ptr_q;
    tag_word[TAG_DCODE_LSB +: TAG_DCODE_W] = DCODE;
    side_d = '0;
    if (op.tag_rd) side_d = tag_word;
    if (op.bad_rd) side_d = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      sel_mem_q  <= 1'b0;
      side_q     <= '0;
    end else begin
      resp_valid <= req_valid;
      sel_mem_q  <= op.raw_rd || do_pop;
      side_q     <= side_d;
    end
  end

  assign resp_rdata = sel_mem_q ? mem_q : side_q;

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_valid); // R2
  AST_STALL_ONLY_RESP: assert property (@(posedge clk) disable iff (rst)
    resp_stall |-> resp_valid); // R6

endmodule

// File: tb/sim_mvf_cell.sv
module sim_mvf_cell;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_tid = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid, resp_stall;
  logic [31:0] resp_rdata;
  logic [7:0]  wake;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mvf_cell u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_tid(req_tid), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_stall(resp_stall),
    .resp_rdata(resp_rdata), .wake(wake)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic        w;
    logic [3:0]  view;
    logic [31:0] wdata;
    logic [2:0]  tid;
    logic        stall;
    logic [7:0]  wake;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{"R1", 1'b0, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h30020001},
    '{"R5", 1'b0, 4'd3,  32'h0,        3'd0, 1'b0, 8'h00, 32'h0},
    '{"R6", 1'b0, 4'd2,  32'h0,        3'd2, 1'b1, 8'h00, 32'h0},
    '{"R6", 1'b0, 4'd2,  32'h0,        3'd5, 1'b1, 8'h00, 32'h0},
    '{"R7", 1'b1, 4'd3,  32'h11,       3'd0, 1'b0, 8'h24, 32'h0},
    '{"R4", 1'b1, 4'd2,  32'h22,       3'd0, 1'b0, 8'h00, 32'h0},
    '{"R8", 1'b0, 4'd0,  32'h0,        3'd0, 1'b0, 8'h00, 32'h11},
    '{"R8", 1'b1, 4'd0,  32'h99,       3'd0, 1'b0, 8'h00, 32'h0},
    '{"R4", 1'b0, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h300A0000},
    '{"R5", 1'b0, 4'd2,  32'h0,        3'd0, 1'b0, 8'h00, 32'h11},
    '{"R8", 1'b0, 4'd3,  32'h0,        3'd0, 1'b0, 8'h00, 32'h99},
    '{"R5", 1'b0, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h30020001},
    '{"R8", 1'b1, 4'd0,  32'h55,       3'd0, 1'b0, 8'h00, 32'h0},
    '{"R8", 1'b0, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h30020001},
    '{"R9", 1'b0, 4'd4,  32'h0,        3'd0, 1'b0, 8'h00, 32'h0},
    '{"R9", 1'b1, 4'd5,  32'h7,        3'd0, 1'b0, 8'h00, 32'h0},
    '{"R9", 1'b0, 4'd9,  32'h0,        3'd0, 1'b0, 8'h00, 32'hFFFFFFFF},
    '{"R9", 1'b1, 4'd15, 32'h2,        3'd0, 1'b0, 8'h00, 32'h0},
    '{"R9", 1'b0, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h30020001},
    '{"R3", 1'b1, 4'd1,  32'h00010002, 3'd0, 1'b0, 8'h00, 32'h0},
    '{"R3", 1'b0, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h30030002},
    '{"R6", 1'b1, 4'd2,  32'hBB,       3'd1, 1'b1, 8'h00, 32'h0},
    '{"R7", 1'b1, 4'd3,  32'hA1,       3'd0, 1'b0, 8'h02, 32'h0},
    '{"R3", 1'b0, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h30070002},
    '{"R5", 1'b0, 4'd3,  32'h0,        3'd0, 1'b0, 8'h00, 32'hA1},
    '{"R3", 1'b0, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h30030001},
    '{"R4", 1'b1, 4'd3,  32'h1,        3'd0, 1'b0, 8'h00, 32'h0},
    '{"R3", 1'b1, 4'd1,  32'hFFFE0001, 3'd0, 1'b0, 8'h00, 32'h0},
    '{"R3", 1'b0, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h30020001},
    '{"R5", 1'b1, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h0},
    '{"R5", 1'b0, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h30020000},
    '{"R5", 1'b0, 4'd2,  32'h0,        3'd0, 1'b0, 8'h00, 32'h0},
    '{"R5", 1'b0, 4'd1,  32'h0,        3'd0, 1'b0, 8'h00, 32'h30020001}
  };

  task automatic check(input string rq, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  // drive one request at a falling edge; outputs are stable at the next one
  task automatic issue(input logic w, input logic [3:0] view,
                       input logic [31:0] d, input logic [2:0] tid);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = {5'd0, view, 3'b101};
    req_wdata = d;
    req_tid   = tid;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_resp(input string rq, input logic stall,
                            input logic [7:0] wk, input logic [31:0] rd);
    check(rq, "resp_valid", 32'(resp_valid), 32'd1);
    check(rq, "resp_stall", 32'(resp_stall), 32'(stall));
    check(rq, "wake", 32'(wake), 32'(wk));
    check(rq, "rdata", resp_rdata, rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2", "idle resp_valid", 32'(resp_valid), 32'd0);
    check("R1", "reset wake", 32'(wake), 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].w, VEC[i].view, VEC[i].wdata, VEC[i].tid);
      check_resp(string'(VEC[i].tag), VEC[i].stall, VEC[i].wake, VEC[i].rdata);
    end

    // R10: fill past the wrap point (head index is 3 here)
    for (int i = 0; i < 8; i++) begin
      issue(1'b1, 4'd3, 32'h100 + 32'(i), 3'd0);
      check_resp("R10", 1'b0, 8'h00, 32'h0);
    end
    issue(1'b0, 4'd1, 32'h0, 3'd0);
    check_resp("R4", 1'b0, 8'h00, 32'h30220002);
    issue(1'b1, 4'd3, 32'hDEAD, 3'd0);
    check_resp("R4", 1'b0, 8'h00, 32'h0);
    issue(1'b0, 4'd1, 32'h0, 3'd0);
    check_resp("R4", 1'b0, 8'h00, 32'h30220002);
    issue(1'b1, 4'd2, 32'hBEEF, 3'd7);
    check_resp("R6", 1'b1, 8'h00, 32'h0);
    issue(1'b0, 4'd2, 32'h0, 3'd0);
    check_resp("R7", 1'b0, 8'h80, 32'h100);
    for (int i = 1; i < 8; i++) begin
      issue(1'b0, 4'd2, 32'h0, 3'd0);
      check_resp("R10", 1'b0, 8'h00, 32'h100 + 32'(i));
    end
    issue(1'b0, 4'd1, 32'h0, 3'd0);
    check_resp("R5", 1'b0, 8'h00, 32'h30020001);

    // R1: reset in the middle of traffic restores the initial tag
    issue(1'b1, 4'd3, 32'h77, 3'd0);
    issue(1'b0, 4'd2, 32'h0, 3'd4);
    issue(1'b1, 4'd3, 32'h78, 3'd0);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
    issue(1'b0, 4'd1, 32'h0, 3'd0);
    check_resp("R1", 1'b0, 8'h00, 32'h30020001);
    issue(1'b1, 4'd3, 32'h5, 3'd0);
    check_resp("R7", 1'b0, 8'h00, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule